// File: doc/BRIEF.md
# Transmit Byte Queue with Self-Sizing Watermark

This block buffers bytes that software writes for a serial transmitter. Each write to the transmit data register pushes one byte. The serial engine pops bytes in the order they were written. Occupancy is reported as a level count, together with full and empty flags.

A programmable watermark sets the refill point. While the occupancy is strictly below the watermark, the below-watermark flag is high, and software uses that as its cue to top the queue up. The watermark register holds only as many bits as are needed for depth minus one. Upper bits of a write are discarded. Writing all ones and reading the value back therefore gives software the queue depth minus one.

Clearing the controller enable empties the queue at once. The programmed watermark is left unchanged.

Top module: `txq_fifo_wmark`

## Requirements
- R1: After reset the level is 0, empty is 1, full is 0, the watermark reads back as 1 and below_wm is 1.
- R2: Accepted bytes leave in the order they were pushed. pop_data shows the oldest stored byte, and a pop removes it at the next clock edge.
- R3: A push while full is dropped. The level stays at DEPTH and the stored bytes are unchanged.
- R4: While empty, pop_data is 0 and a pop has no effect on the level.
- R5: The watermark keeps only the low log2(DEPTH) bits of a write, and reads back zero-extended. Writing 0xFFFF reads back DEPTH-1.
- R6: below_wm is 1 exactly when the level is strictly less than the watermark value.
- R7: level equals the number of stored bytes (0 to DEPTH). full is 1 exactly when level is DEPTH, and empty is 1 exactly when level is 0.
- R8: A push and a pop in the same cycle, when the queue is neither empty nor full, leave the level unchanged and keep the order.
- R9: While enable is 0 the queue is flushed to empty and pushes are ignored. The watermark value is kept.
- R10: A watermark write takes effect on the next clock edge, both for readback and for below_wm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; 0 flushes the queue |
| push_valid | input | 1 | Transmit data register write strobe |
| push_data | input | DATA_W | Byte to enqueue |
| pop_req | input | 1 | Serial engine takes the head byte |
| pop_data | output | DATA_W | Head byte, or 0 when empty |
| wm_wr_en | input | 1 | Watermark register write strobe |
| wm_wr_data | input | REG_W | Watermark write value |
| wm_rd_data | output | REG_W | Watermark readback, zero-extended |
| level | output | log2(DEPTH)+1 | Current occupancy |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| below_wm | output | 1 | Occupancy is below the watermark |

## Verification
The bench sweeps every watermark value against every occupancy from 0 to DEPTH. A compare that is off by one, or that uses less-or-equal, would show a wrong below_wm at exactly one level per watermark. It pushes into a full queue and then drains it. A design that let the pointer wrap would overwrite the oldest byte or report an empty queue. It writes oversized watermark values such as 0xFFFF, 0x1234 and DEPTH itself, where a register that was too wide would read back the untruncated value. A long pseudo-random run of pushes, pops, simultaneous operations and disable pulses is compared against a queue model, which exposes lost bytes, a flush that fails to clear, and a flush that also resets the watermark.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [1:0] {
        TXQ_IDLE = 2'b00,
        TXQ_PUSH = 2'b01,
        TXQ_POP  = 2'b10,
        TXQ_BOTH = 2'b11
    } txq_op_e;

    function automatic txq_op_e txq_decode(input logic push_ok, input logic pop_ok);
        return txq_op_e'({pop_ok, push_ok});
    endfunction

    localparam int unsigned TXQ_WM_RESET = 1;

endpackage

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          push_valid,
    input  logic          pop_req,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   level,
    output logic          full,
    output logic          empty
);
    import txq_pkg::*;

    localparam logic [AW:0] FULL_XOR = {1'b1, {AW{1'b0}}};

    logic [AW:0] wr_ptr, rd_ptr;
    logic        push_ok, pop_ok;
    txq_op_e     op;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = ((wr_ptr ^ rd_ptr) == FULL_XOR);
    assign push_ok = enable && push_valid && !full;
    assign pop_ok  = enable && pop_req && !empty;
    assign op      = txq_decode(push_ok, pop_ok);
    assign wr_fire = push_ok;
    assign wr_addr = wr_ptr[AW-1:0];
    assign rd_addr = rd_ptr[AW-1:0];
    assign level   = wr_ptr - rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            unique case (op)
                TXQ_PUSH: wr_ptr <= wr_ptr + 1'b1;
                TXQ_POP:  rd_ptr <= rd_ptr + 1'b1;
                TXQ_BOTH: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    rd_ptr <= rd_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth, flags never both set
    p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        level <= (AW+1)'(DEPTH));
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    // R3: a push into a full queue without a pop leaves it full
    p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && full && push_valid && !pop_req) |=> (full && $stable(level)));
    // R4: a pop on an empty queue without a push leaves it empty
    p_pop_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && empty && pop_req && !push_valid) |=> empty);
    // R2: an accepted lone push raises the level by one
    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && push_valid && !full && !pop_req) |=> (level == $past(level) + 1'b1));
    // R8: simultaneous accepted push and pop keep the level
    p_both_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && push_valid && pop_req && !full && !empty) |=> $stable(level));
    // R9: disable flushes
    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> empty);

endmodule

// File: rtl/txq_mem.sv
module txq_mem #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_fire,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_fire && (wr_addr == AW'(i)))
                slots[i] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/txq_wmark.sv
module txq_wmark #(
    parameter int DEPTH = 8,
    parameter int REG_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [AW:0]      level,
    output logic [REG_W-1:0] rd_data,
    output logic             below
);
    import txq_pkg::*;

    logic [AW-1:0] mark;

    always_ff @(posedge clk) begin
        if (rst)
            mark <= AW'(TXQ_WM_RESET);
        else if (wr_en)
            mark <= wr_data[AW-1:0];
    end

    assign rd_data = {{(REG_W-AW){1'b0}}, mark};
    assign below   = (level < {1'b0, mark});

    // R5: readback never exceeds depth minus one
    p_wm_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data < REG_W'(DEPTH));
    // R10: a write is visible on the next edge
    p_wm_write_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[AW-1:0] == $past(wr_data[AW-1:0])));

endmodule

// File: rtl/txq_fifo_wmark.sv
module txq_fifo_wmark #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int REG_W  = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic              wm_wr_en,
    input  logic [REG_W-1:0]  wm_wr_data,
    output logic [REG_W-1:0]  wm_rd_data,
    output logic [AW:0]       level,
    output logic              full,
    output logic              empty,
    output logic              below_wm
);
    logic              wr_fire;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DATA_W-1:0] head;

    txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .enable(enable),
        .push_valid(push_valid), .pop_req(pop_req),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .level(level), .full(full), .empty(empty)
    );

    txq_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .wr_fire(wr_fire), .wr_addr(wr_addr),
        .wr_data(push_data), .rd_addr(rd_addr), .rd_data(head)
    );

    txq_wmark #(.DEPTH(DEPTH), .REG_W(REG_W)) u_wmark (
        .clk(clk), .rst(rst), .wr_en(wm_wr_en), .wr_data(wm_wr_data),
        .level(level), .rd_data(wm_rd_data), .below(below_wm)
    );

    assign pop_data = empty ? '0 : head;

    initial begin
        assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
            else $error("DEPTH must be a power of two, at least 4");
        assert (REG_W > AW) else $error("REG_W too narrow");
    end

    // R4: an empty queue presents zero to the serial engine
    p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
        empty |-> (pop_data == '0));
    // R9: nothing enters while disabled
    p_no_push_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!enable && push_valid) |=> (level == '0));

endmodule

// File: tb/tb_txq_fifo_wmark.sv
module tb_txq_fifo_wmark;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 8;
    localparam int REG_W  = 16;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 0, rst = 1, enable = 0, push_valid = 0, pop_req = 0, wm_wr_en = 0;
    logic [DATA_W-1:0] push_data = '0, pop_data;
    logic [REG_W-1:0]  wm_wr_data = '0, wm_rd_data;
    logic [AW:0]       level;
    logic              full, empty, below_wm;

    int checks = 0, errors = 0;
    int q[$];
    int wm_m = 1;

    always #10 clk = ~clk;

    txq_fifo_wmark #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .push_valid(push_valid),
        .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
        .wm_wr_en(wm_wr_en), .wm_wr_data(wm_wr_data), .wm_rd_data(wm_rd_data),
        .level(level), .full(full), .empty(empty), .below_wm(below_wm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " R7 level"}, int'(level), q.size());
        chk({tag, " R7 full"}, int'(full), int'(q.size() == DEPTH));
        chk({tag, " R7 empty"}, int'(empty), int'(q.size() == 0));
        chk({tag, " R6 below_wm"}, int'(below_wm), int'(q.size() < wm_m));
        chk({tag, " R2 head"}, int'(pop_data), (q.size() > 0) ? q[0] : 0);
    endtask

    // one clock: inputs applied away from the edge, outputs sampled 1ns after
    task automatic cycle(input logic en, input logic ps, input int d, input logic pp,
                         input logic ww, input int wv);
        bit can_pop, can_push;
        enable = en; push_valid = ps; push_data = DATA_W'(d); pop_req = pp;
        wm_wr_en = ww; wm_wr_data = REG_W'(wv);
        can_pop  = en && pp && q.size() > 0;
        can_push = en && ps && q.size() < DEPTH;
        @(posedge clk);
        #1;
        if (!en) q.delete();
        else begin
            if (can_pop) void'(q.pop_front());
            if (can_push) q.push_back(d);
        end
        if (ww) wm_m = wv % DEPTH;
        push_valid = 0; pop_req = 0; wm_wr_en = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [15:0] lf;
        lf = 16'hACE1;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 wm", int'(wm_rd_data), 1);
        chk("R1 below_wm", int'(below_wm), 1);

        // R5 truncation of oversized watermark writes
        cycle(1, 0, 0, 0, 1, 16'hFFFF);
        chk("R5 wm 0xFFFF", int'(wm_rd_data), DEPTH - 1);
        cycle(1, 0, 0, 0, 1, 16'h1234);
        chk("R5 wm 0x1234", int'(wm_rd_data), 16'h1234 % DEPTH);
        cycle(1, 0, 0, 0, 1, DEPTH);
        chk("R5 wm DEPTH", int'(wm_rd_data), 0);
        chk("R10 below after wm=0", int'(below_wm), 0);
        cycle(1, 0, 0, 0, 1, 3);
        chk("R10 below after wm=3", int'(below_wm), 1);

        // R2/R7 fill to full, R3 push while full
        for (int i = 0; i < DEPTH; i++) begin
            cycle(1, 1, 8'h10 + i, 0, 0, 0);
            chk_state("fill");
        end
        cycle(1, 1, 8'hEE, 0, 0, 0);
        chk("R3 level after drop", int'(level), DEPTH);
        chk("R3 full after drop", int'(full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 R3 drain order", int'(pop_data), 8'h10 + i);
            cycle(1, 0, 0, 1, 0, 0);
        end
        // R4 pop while empty
        chk("R4 pop_data empty", int'(pop_data), 0);
        cycle(1, 0, 0, 1, 0, 0);
        chk("R4 level after empty pop", int'(level), 0);
        chk("R4 empty after empty pop", int'(empty), 1);

        // R6 sweep: every watermark against every level
        for (int w = 0; w < DEPTH; w++) begin
            cycle(0, 0, 0, 0, 1, w);
            for (int l = 0; l <= DEPTH; l++) begin
                chk($sformatf("R6 wm=%0d level=%0d", w, l), int'(below_wm), int'(l < w));
                if (l < DEPTH) cycle(1, 1, l, 0, 0, 0);
            end
        end

        // R9 flush keeps watermark, ignores pushes while disabled
        cycle(1, 0, 0, 0, 1, 5);
        cycle(0, 1, 8'h55, 0, 0, 0);
        chk("R9 level after flush", int'(level), 0);
        chk("R9 empty after flush", int'(empty), 1);
        chk("R9 wm kept", int'(wm_rd_data), 5);
        chk("R9 pop_data after flush", int'(pop_data), 0);

        // R8 simultaneous push and pop
        cycle(1, 1, 8'hA1, 0, 0, 0);
        cycle(1, 1, 8'hA2, 0, 0, 0);
        cycle(1, 1, 8'hA3, 1, 0, 0);
        chk("R8 level both", int'(level), 2);
        chk("R8 head both", int'(pop_data), 8'hA2);

        // random run against the model
        for (int n = 0; n < 1500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cycle(lf[7:0] != 8'h00, lf[0] | lf[3], int'(lf[15:8]), lf[1] & lf[5],
                  lf[9:2] == 8'h11, int'(lf[15:4]));
            chk_state("R2 R8 random");
            chk("R5 R10 random wm", int'(wm_rd_data), wm_m);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule